// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block is the digital power controller of a serial-interface analog-to-digital converter. It watches a serial data line for a start bit, captures the control byte that follows, and decodes a two-bit power field. That field picks the power state after the conversion and the conversion clock mode. The block wakes the converter from software power-down, holds off conversions until a programmable reference-settle wait has run out, and issues a one-cycle conversion strobe. A stub timer stands in for the converter and models each conversion as a fixed busy period.

Software power-down lets the running conversion finish under the clock mode already in force. The active-low shutdown input drops the block into hardware shutdown at the next edge and abandons any conversion. The settle counter keeps running in fast power-down. A host can therefore spend the reference settling time at low power and then wake the block for an accurate conversion.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset `pwr_state` is 2'b00 (full power-down), and `conv_en`, `busy`, `settle_done`, `clk_ext` and `res_rdy` are all 0.
- R2: The block samples `sdin` on cycles with `bit_en` high. In full power-down (00) or fast power-down (01), the first sampled 1 is taken as a start bit, and `pwr_state` is 2'b10 (powered) from the edge that samples it.
- R3: The settle counter is cleared in full power-down and in hardware shutdown. It counts one per cycle while powered (10) or in fast power-down (01), and `settle_done` goes high exactly `settle_cycles` edges after the edge that entered the powered state from full power-down.
- R4: A captured control byte requests one conversion. `conv_en` is a one-cycle pulse that is never high while `settle_done` is low, so the request waits for the settle wait to end.
- R5: A control byte is 8 bits sent MSB first: the start bit, then 5 bits with no effect on this block, then PD1 and PD0 as the last two bits. The codes are 00 = full power-down, 01 = fast power-down, 10 = powered with internal clock, 11 = powered with external clock.
- R6: With PD1 = 1, the block stays powered after the conversion, and `clk_ext` takes the value of PD0 at the edge that samples the last bit.
- R7: With PD1 = 0, the block makes exactly one conversion and then enters full power-down (00) or fast power-down (01) as PD0 selects. `clk_ext` keeps its previous value.
- R8: Code 01 received while `settle_done` is low moves the block to fast power-down at the edge that samples the last bit. No conversion starts.
- R9: `busy` is high for exactly CONV_CYCLES cycles, starting on the edge after `conv_en`. The state selected by the control byte takes effect on the edge where `busy` falls. `busy` is only ever high while powered.
- R10: While `shdn_n` is low, `pwr_state` becomes 2'b11 at the next edge. `busy`, `res_rdy`, any pending request and the settle count are dropped, and the abandoned conversion never completes. After `shdn_n` returns high, the block goes to full power-down.
- R11: `res_rdy` goes high when a conversion completes. It stays high while powered, or in a software power-down state when `clk_ext` is 0. It reads 0 in a software power-down state when `clk_ext` is 1, and it is cleared by the next conversion or by hardware shutdown.
- R12: Serial bits sampled while a conversion is pending or busy are ignored: they start no new control byte and no new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Serial bit strobe; `sdin` is sampled when high |
| sdin | input | 1 | Serial control data |
| shdn_n | input | 1 | Active-low hardware shutdown |
| settle_cycles | input | CNT_W | Reference-settle wait length in cycles |
| conv_en | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | Conversion in progress |
| settle_done | output | 1 | Reference-settle wait has expired |
| clk_ext | output | 1 | Clock mode: 1 = external, 0 = internal |
| pwr_state | output | 2 | 00 full PD, 01 fast PD, 10 powered, 11 hardware shutdown |
| res_rdy | output | 1 | A completed result can be shifted out |

## Verification
The bench times the settle wait against a randomly chosen limit, counted from the wake edge. A design that started counting late, or reset the count in fast power-down, would raise `settle_done` at the wrong edge or never start the later conversion. It sends code 01 before settling to confirm the block drops to fast power-down without a strobe; a design that converted first would show a stray `conv_en`. It pulls `shdn_n` low in the middle of a conversion. A design that finished the conversion anyway would keep `busy` high, or later raise `res_rdy` or change state. Random codes then check the next state, the clock mode, and result readability after each conversion, and a burst of serial ones during a conversion must start nothing.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PS_FULL_PD = 2'b00,
        PS_FAST_PD = 2'b01,
        PS_ON      = 2'b10,
        PS_HW_SD   = 2'b11
    } pwr_e;

    localparam logic [1:0] PD_FULL = 2'b00;
    localparam logic [1:0] PD_FAST = 2'b01;
    localparam logic [1:0] PD_INT  = 2'b10;
    localparam logic [1:0] PD_EXT  = 2'b11;

    typedef struct packed {
        pwr_e       pwr;
        logic       clk_ext;
        logic [1:0] pd;
        logic       pend;
        logic       rdy;
    } ctl_t;

endpackage

// File: rtl/adc_pwr_rx.sv
module adc_pwr_rx #(
    parameter int CTRL_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hold,
    input  logic       bit_en,
    input  logic       sdin,
    output logic       start_hit,
    output logic       byte_done,
    output logic [1:0] pd_now
);
    localparam int CW = $clog2(CTRL_BITS);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          last;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        start_hit = !rx_q.active && bit_en && sdin && !hold && !clr;
        byte_done = rx_q.active && bit_en && (rx_q.cnt == CW'(1)) && !clr;
        pd_now    = {rx_q.last, sdin};
        rx_d      = rx_q;
        if (clr) begin
            rx_d.active = 1'b0;
        end else if (start_hit) begin
            rx_d.active = 1'b1;
            rx_d.cnt    = CW'(CTRL_BITS - 1);
        end else if (rx_q.active && bit_en) begin
            rx_d.last = sdin;
            rx_d.cnt  = rx_q.cnt - CW'(1);
            if (rx_q.cnt == CW'(1)) begin
                rx_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end
endmodule

// File: rtl/adc_pwr_settle.sv
module adc_pwr_settle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = (cnt_q >= limit);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && !done) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_pwr_conv.sv
module adc_pwr_conv #(
    parameter int CONV_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        busy  = (cnt_q != '0);
        done  = (cnt_q == CW'(1)) && !abort;
        cnt_d = cnt_q;
        if (abort) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = CW'(CONV_CYCLES);
        end else if (busy) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
    parameter int CTRL_BITS   = 8,
    parameter int CNT_W       = 16,
    parameter int CONV_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sdin,
    input  logic             shdn_n,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             conv_en,
    output logic             busy,
    output logic             settle_done,
    output logic             clk_ext,
    output logic [1:0]       pwr_state,
    output logic             res_rdy
);
    import adc_pwr_pkg::*;

    ctl_t       ctl_d, ctl_q;
    logic       start_hit, byte_done, settle_raw, conv_done;
    logic [1:0] pd_now;
    logic       settled, conv_go, rx_clr, cnt_clr, cnt_run;

    adc_pwr_rx #(.CTRL_BITS(CTRL_BITS)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .hold      (ctl_q.pend || busy),
        .bit_en    (bit_en),
        .sdin      (sdin),
        .start_hit (start_hit),
        .byte_done (byte_done),
        .pd_now    (pd_now)
    );

    adc_pwr_settle #(.CNT_W(CNT_W)) i_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .limit (settle_cycles),
        .done  (settle_raw)
    );

    adc_pwr_conv #(.CONV_CYCLES(CONV_CYCLES)) i_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_go),
        .abort (!shdn_n),
        .busy  (busy),
        .done  (conv_done)
    );

    always_comb begin
        rx_clr  = !shdn_n || (ctl_q.pwr == PS_HW_SD);
        cnt_clr = (ctl_q.pwr == PS_FULL_PD) || (ctl_q.pwr == PS_HW_SD);
        cnt_run = (ctl_q.pwr == PS_ON) || (ctl_q.pwr == PS_FAST_PD);
        settled = settle_raw && cnt_run;
        conv_go = ctl_q.pend && settled && !busy && (ctl_q.pwr == PS_ON) && shdn_n;

        ctl_d = ctl_q;
        if (!shdn_n) begin
            // hardware shutdown: abandon everything
            ctl_d.pwr  = PS_HW_SD;
            ctl_d.pend = 1'b0;
            ctl_d.rdy  = 1'b0;
        end else if (ctl_q.pwr == PS_HW_SD) begin
            ctl_d.pwr = PS_FULL_PD;
        end else begin
            // start bit wakes from either software power-down state
            if (start_hit && !ctl_q.pwr[1]) begin
                ctl_d.pwr = PS_ON;
            end
            if (byte_done) begin
                ctl_d.pd = pd_now;
                if (pd_now[1]) begin
                    ctl_d.clk_ext = pd_now[0];
                end
                if (pd_now == PD_FAST && !settled) begin
                    ctl_d.pwr = PS_FAST_PD;
                end else begin
                    ctl_d.pend = 1'b1;
                end
            end
            if (conv_go) begin
                ctl_d.pend = 1'b0;
                ctl_d.rdy  = 1'b0;
            end
            if (conv_done) begin
                ctl_d.rdy = 1'b1;
                if (!ctl_q.pd[1]) begin
                    ctl_d.pwr = ctl_q.pd[0] ? PS_FAST_PD : PS_FULL_PD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{pwr: PS_FULL_PD, clk_ext: 1'b0, pd: PD_FULL, pend: 1'b0, rdy: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign conv_en     = conv_go;
    assign settle_done = settled;
    assign clk_ext     = ctl_q.clk_ext;
    assign pwr_state   = ctl_q.pwr;
    assign res_rdy     = ctl_q.rdy &&
                         ((ctl_q.pwr == PS_ON) || (!ctl_q.pwr[1] && !ctl_q.clk_ext));
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_n,
    input logic       conv_en,
    input logic       busy,
    input logic       settle_done,
    input logic       clk_ext,
    input logic [1:0] pwr_state,
    input logic       res_rdy
);
    assert_conv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |=> !conv_en);

    assert_conv_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> settle_done);

    assert_busy_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |=> busy);

    assert_busy_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pwr_state == 2'b10));

    assert_hw_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (pwr_state == 2'b11 && !busy && !res_rdy));

    assert_full_pd_unsettled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00) |-> !settle_done);

    assert_ext_pd_no_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_state[1] && clk_ext) |-> !res_rdy);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shdn_n      (shdn_n),
    .conv_en     (conv_en),
    .busy        (busy),
    .settle_done (settle_done),
    .clk_ext     (clk_ext),
    .pwr_state   (pwr_state),
    .res_rdy     (res_rdy)
);

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
    localparam int CNT_W = 16;
    localparam int CONV  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             sdin = 1'b0;
    logic             shdn_n = 1'b1;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic             conv_en, busy, settle_done, clk_ext, res_rdy;
    logic [1:0]       pwr_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_pwr_seq #(.CTRL_BITS(8), .CNT_W(CNT_W), .CONV_CYCLES(CONV)) i_adc_pwr_seq (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdin(sdin), .shdn_n(shdn_n),
        .settle_cycles(settle_cycles), .conv_en(conv_en), .busy(busy),
        .settle_done(settle_done), .clk_ext(clk_ext), .pwr_state(pwr_state),
        .res_rdy(res_rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pwr(input logic [1:0] pd);
        if (pd[1]) return 2'b10;
        return pd[0] ? 2'b01 : 2'b00;
    endfunction

    function automatic logic exp_clk(input logic prev, input logic [1:0] pd);
        return pd[1] ? pd[0] : prev;
    endfunction

    function automatic logic exp_rdy(input logic [1:0] pw, input logic ck);
        if (pw == 2'b10) return 1'b1;
        if (!pw[1]) return !ck;
        return 1'b0;
    endfunction

    // R5: start bit, five don't-care bits, PD1, PD0; MSB first
    task automatic send_byte(input logic [1:0] pd);
        logic [7:0] b;
        b = {1'b1, 5'($urandom), pd};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 1) chk("R2 powered after start bit", pwr_state, 2);
            bit_en = 1'b1;
            sdin   = b[7 - i];
        end
        @(negedge clk);
        bit_en = 1'b0;
        sdin   = 1'b0;
    endtask

    task automatic run_conv(input logic [1:0] pd, inout logic ck);
        send_byte(pd);
        chk("R4 strobe after byte", conv_en, 1);
        repeat (CONV) @(negedge clk);
        chk("R9 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R9 busy ended", busy, 0);
        ck = exp_clk(ck, pd);
        chk("R6 R7 next state", pwr_state, exp_pwr(pd));
        chk("R6 R7 clock mode", clk_ext, ck);
        chk("R11 result readable", res_rdy, exp_rdy(exp_pwr(pd), ck));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ck;
        int   k, early, lim;
        void'($urandom(32'd4711));
        ck = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwr_state", pwr_state, 0);
        chk("R1 conv_en", conv_en, 0);
        chk("R1 busy", busy, 0);
        chk("R1 settle_done", settle_done, 0);
        chk("R1 clk_ext", clk_ext, 0);
        chk("R1 res_rdy", res_rdy, 0);

        // R3 R4: settle wait from full power-up, conversion held off
        lim = 20 + int'($urandom % 40);
        settle_cycles = CNT_W'(lim);
        send_byte(2'b10);
        chk("R4 no strobe before settle", conv_en, 0);
        chk("R3 not settled yet", settle_done, 0);
        k = 0; early = 0;
        while (!settle_done && k < 500) begin
            if (conv_en) early++;
            @(negedge clk);
            k++;
        end
        chk("R3 settle edge count", k, lim - 7);
        chk("R4 held-off strobe count", early, 0);
        chk("R4 strobe at settle", conv_en, 1);
        repeat (CONV) @(negedge clk);
        chk("R9 busy length", busy, 1);
        @(negedge clk);
        chk("R9 busy fell", busy, 0);
        chk("R6 stays powered", pwr_state, 2);
        chk("R11 result after conv", res_rdy, 1);

        // R5 R6 R7 R11: random codes, settle wait zero
        settle_cycles = '0;
        for (int n = 0; n < 16; n++) begin
            run_conv(2'($urandom), ck);
        end

        // R8 R3: code 01 before settling spends the wait in fast power-down
        run_conv(2'b00, ck);
        settle_cycles = CNT_W'(40);
        send_byte(2'b01);
        chk("R8 fast power-down", pwr_state, 1);
        chk("R8 no strobe", conv_en, 0);
        k = 0; early = 0;
        while (!settle_done && k < 500) begin
            if (conv_en || busy) early++;
            @(negedge clk);
            k++;
        end
        chk("R3 counts in fast power-down", k, 33);
        chk("R8 no conversion while waiting", early, 0);
        chk("R8 still fast power-down", pwr_state, 1);
        run_conv(2'b10, ck);

        // R10: shutdown in mid-conversion
        settle_cycles = '0;
        send_byte(2'b10);
        chk("R10 conversion started", conv_en, 1);
        repeat (3) @(negedge clk);
        shdn_n = 1'b0;
        @(negedge clk);
        chk("R10 hw shutdown state", pwr_state, 3);
        chk("R10 busy dropped", busy, 0);
        chk("R10 result dropped", res_rdy, 0);
        chk("R10 settle cleared", settle_done, 0);
        repeat (2) @(negedge clk);
        shdn_n = 1'b1;
        @(negedge clk);
        chk("R10 back to full power-down", pwr_state, 0);
        early = 0;
        for (int i = 0; i < CONV + 4; i++) begin
            @(negedge clk);
            if (conv_en || busy || res_rdy) early++;
        end
        chk("R10 abandoned conversion", early, 0);
        chk("R10 still full power-down", pwr_state, 0);

        // R12: serial ones during a conversion start nothing
        send_byte(2'b10);
        chk("R12 conversion started", conv_en, 1);
        early = 0;
        for (int i = 0; i < CONV - 2; i++) begin
            @(negedge clk);
            if (conv_en) early++;
            bit_en = 1'b1;
            sdin   = 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b0;
        sdin   = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (conv_en) early++;
            @(negedge clk);
        end
        chk("R12 no extra strobe", early, 0);
        chk("R12 still powered", pwr_state, 2);
        chk("R12 idle after conversion", busy, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule